// File: doc/BRIEF.md
# Segmented Forward-Backward Schedule Controller

This controller sequences the memory traffic of one soft-decision decoder that runs a forward-backward recursion over a window of `NUM_SEG * SEG_LEN` indices. By default that is 1024 indices in eight segments of 128. A forward unit sweeps the whole window in ascending order. A backward/update unit follows one segment behind and walks each segment in descending order. Each decoder iteration is therefore cut into `NUM_SEG + 1` time slots of `SEG_LEN` cycles. The first slot is forward only, the last slot is backward only, and every slot in between overlaps the two units.

For every cycle the block produces, for each unit, an enable, the window index, the address into a single shared state-metric region of `SEG_LEN` entries, and a parity bank select with an address inside that bank. The message stores and the channel-metric sub-banks both use that bank select and bank address. Alternate segments are laid into the state-metric region in opposite directions. As a result, the entry the backward unit reads in a cycle is the one the forward unit overwrites in that same cycle, so one two-port memory with read-before-write behaviour is enough.

The backward recursion of each segment starts from a boundary metric saved during the previous iteration. No warm-up pass is run. The block marks when to load that seed and when to save the boundary value it produces. It also counts iterations, flips the channel-metric double buffer on every accepted start, and pulses done after the last step.

Top module: `fbs_sched_ctrl`

## Requirements
- R1: While reset is held and after its release, busy, done, both unit enables, seed enable, save enable and cm_buf are 0.
- R2: start is taken only while idle. num_iters is captured at that moment, and a value of 0 runs one iteration. A start raised while a run is in progress has no effect on the schedule.
- R3: An accepted start at clock edge E makes the first step's outputs appear at edge E+1. Each iteration spans `(NUM_SEG+1)*SEG_LEN` steps, and iter_idx gives the iteration the current step belongs to, counting from 0.
- R4: In step k of an iteration, with slot t = k / SEG_LEN and c = k mod SEG_LEN, fwd_en is 1 exactly when t < NUM_SEG. fwd_index is then t*SEG_LEN + c.
- R5: bwd_en is 1 exactly when t >= 1. It handles segment s = t-1, and bwd_index is s*SEG_LEN + (SEG_LEN-1-c), which counts downward.
- R6: A unit at local offset j in segment s uses state-metric address j when s is even and SEG_LEN-1-j when s is odd. In overlapped steps, sm_wr_addr equals sm_rd_addr.
- R7: The bank select of each unit is bit 0 of its segment number, and its bank address is (s/2)*SEG_LEN + j.
- R8: seed_en is 1 on the first backward step of each segment (c = 0), with seed_idx = s. seed_zero is 1 there during iteration 0 or when s = NUM_SEG-1.
- R9: save_en is 1 on the last backward step of a segment (c = SEG_LEN-1) when s >= 1, with save_idx = s-1.
- R10: done is a one-cycle pulse at the edge right after the final step's outputs. busy is 1 over exactly the steps of the run and falls on that same edge.
- R11: cm_buf toggles on every accepted start and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a run (taken only when idle) |
| num_iters | input | ITER_W | Iterations to run (0 runs one) |
| busy | output | 1 | Schedule outputs are valid this cycle |
| done | output | 1 | One-cycle pulse after the final step |
| iter_idx | output | ITER_W | Iteration of the current step |
| cm_buf | output | 1 | Channel-metric buffer the decoder reads |
| fwd_en | output | 1 | Forward unit active |
| fwd_index | output | IDX_W | Forward window index |
| sm_wr_addr | output | LW | State-metric write address (forward) |
| fwd_bank | output | 1 | Forward parity bank select |
| fwd_bank_addr | output | BAW | Forward address inside its bank |
| bwd_en | output | 1 | Backward/update unit active |
| bwd_index | output | IDX_W | Backward window index |
| sm_rd_addr | output | LW | State-metric read address (backward) |
| bwd_bank | output | 1 | Backward parity bank select |
| bwd_bank_addr | output | BAW | Backward address inside its bank |
| seed_en | output | 1 | Load boundary seed into backward recursion |
| seed_zero | output | 1 | Seed with zero metrics instead of saved value |
| seed_idx | output | SW | Boundary register to load |
| save_en | output | 1 | Store produced boundary metric |
| save_idx | output | SW | Boundary register to store into |

## Verification
The bench builds the block with SEG_LEN = 4 and NUM_SEG = 4, so one iteration is only 20 steps long. Every step of several complete runs can then be compared against values worked out from the slot arithmetic. This shrunken geometry still has even and odd segments, segments with both a bank-address high part of 0 and one of 1, interior and end-of-window boundaries, and first and later iterations. It therefore covers address reversal, parity banking, seed zeroing and the save rule at each of their edges. Runs with 3, 1 and 0 iterations, plus a start pulse injected mid-run, cover the iteration counter, its clamp and the rule that a start while busy is ignored.

// File: rtl/fbs_pkg.sv
package fbs_pkg;
  // Mirror an offset inside a segment of 2**lw entries.
  function automatic logic [15:0] mirror(input logic [15:0] off, input int lw);
    logic [15:0] mask;
    mask = (16'd1 << lw) - 16'd1;
    return (~off) & mask;
  endfunction
endpackage

// File: rtl/fbs_step_counter.sv
module fbs_step_counter #(
  parameter int SEG_LEN = 128,
  parameter int NUM_SEG = 8,
  parameter int ITER_W  = 4,
  localparam int LW     = $clog2(SEG_LEN),
  localparam int SLOT_W = $clog2(NUM_SEG + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ITER_W-1:0] num_iters,
  output logic              active,
  output logic              accept,
  output logic              last_step,
  output logic [ITER_W-1:0] iter,
  output logic [SLOT_W-1:0] slot,
  output logic [LW-1:0]     cyc
);
  logic [ITER_W-1:0] last_iter;
  logic cyc_end, slot_end;

  assign accept    = !active && start;
  assign cyc_end   = (cyc == LW'(SEG_LEN - 1));
  assign slot_end  = (slot == SLOT_W'(NUM_SEG));
  assign last_step = active && cyc_end && slot_end && (iter == last_iter);

  always_ff @(posedge clk) begin
    if (rst) begin
      active    <= 1'b0;
      iter      <= '0;
      slot      <= '0;
      cyc       <= '0;
      last_iter <= '0;
    end else if (accept) begin
      active    <= 1'b1;
      iter      <= '0;
      slot      <= '0;
      cyc       <= '0;
      last_iter <= (num_iters == '0) ? '0 : num_iters - ITER_W'(1);
    end else if (active) begin
      if (cyc_end) begin
        cyc <= '0;
        if (slot_end) begin
          slot <= '0;
          if (iter == last_iter) active <= 1'b0;
          else                   iter   <= iter + ITER_W'(1);
        end else begin
          slot <= slot + SLOT_W'(1);
        end
      end else begin
        cyc <= cyc + LW'(1);
      end
    end
  end

  assert_slot_range_R3: assert property (@(posedge clk) disable iff (rst)
    active |-> (slot <= SLOT_W'(NUM_SEG)));
  assert_iter_bound_R2: assert property (@(posedge clk) disable iff (rst)
    active |-> (iter <= last_iter));
endmodule

// File: rtl/fbs_addr_gen.sv
module fbs_addr_gen #(
  parameter int SEG_LEN  = 128,
  parameter int NUM_SEG  = 8,
  parameter bit BACKWARD = 1'b0,
  localparam int LW    = $clog2(SEG_LEN),
  localparam int SW    = $clog2(NUM_SEG),
  localparam int IDX_W = SW + LW,
  localparam int BAW   = SW - 1 + LW
) (
  input  logic [SW-1:0]    seg,
  input  logic [LW-1:0]    cyc,
  output logic [IDX_W-1:0] index,
  output logic [LW-1:0]    sm_addr,
  output logic             bank,
  output logic [BAW-1:0]   bank_addr
);
  import fbs_pkg::*;
  logic [LW-1:0] offs;

  generate
    if (BACKWARD) begin : g_desc
      assign offs = LW'(mirror(16'(cyc), LW));
    end else begin : g_asc
      assign offs = cyc;
    end
  endgenerate

  always_comb begin
    index     = {seg, offs};
    sm_addr   = seg[0] ? LW'(mirror(16'(offs), LW)) : offs;
    bank      = seg[0];
    bank_addr = {seg[SW-1:1], offs};
  end
endmodule

// File: rtl/fbs_boundary_ctl.sv
module fbs_boundary_ctl #(
  parameter int SEG_LEN = 128,
  parameter int NUM_SEG = 8,
  localparam int LW = $clog2(SEG_LEN),
  localparam int SW = $clog2(NUM_SEG)
) (
  input  logic          bwd_act,
  input  logic          first_iter,
  input  logic [SW-1:0] seg,
  input  logic [LW-1:0] cyc,
  output logic          seed_en,
  output logic          seed_zero,
  output logic [SW-1:0] seed_idx,
  output logic          save_en,
  output logic [SW-1:0] save_idx
);
  always_comb begin
    seed_en   = bwd_act && (cyc == '0);
    seed_zero = seed_en && (first_iter || (seg == SW'(NUM_SEG - 1)));
    seed_idx  = seg;
    save_en   = bwd_act && (cyc == LW'(SEG_LEN - 1)) && (seg != '0);
    save_idx  = seg - SW'(1);
  end
endmodule

// File: rtl/fbs_sched_ctrl.sv
module fbs_sched_ctrl #(
  parameter int SEG_LEN = 128,
  parameter int NUM_SEG = 8,
  parameter int ITER_W  = 4,
  localparam int LW     = $clog2(SEG_LEN),
  localparam int SW     = $clog2(NUM_SEG),
  localparam int SLOT_W = $clog2(NUM_SEG + 1),
  localparam int IDX_W  = SW + LW,
  localparam int BAW    = SW - 1 + LW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ITER_W-1:0] num_iters,
  output logic              busy,
  output logic              done,
  output logic [ITER_W-1:0] iter_idx,
  output logic              cm_buf,
  output logic              fwd_en,
  output logic [IDX_W-1:0]  fwd_index,
  output logic [LW-1:0]     sm_wr_addr,
  output logic              fwd_bank,
  output logic [BAW-1:0]    fwd_bank_addr,
  output logic              bwd_en,
  output logic [IDX_W-1:0]  bwd_index,
  output logic [LW-1:0]     sm_rd_addr,
  output logic              bwd_bank,
  output logic [BAW-1:0]    bwd_bank_addr,
  output logic              seed_en,
  output logic              seed_zero,
  output logic [SW-1:0]     seed_idx,
  output logic              save_en,
  output logic [SW-1:0]     save_idx
);
  logic              active, accept, last_step, last_q;
  logic [ITER_W-1:0] iter;
  logic [SLOT_W-1:0] slot;
  logic [LW-1:0]     cyc;

  fbs_step_counter #(.SEG_LEN(SEG_LEN), .NUM_SEG(NUM_SEG), .ITER_W(ITER_W)) cnt_i (
    .clk(clk), .rst(rst), .start(start), .num_iters(num_iters),
    .active(active), .accept(accept), .last_step(last_step),
    .iter(iter), .slot(slot), .cyc(cyc)
  );

  logic          f_act, b_act;
  logic [SW-1:0] f_seg, b_seg;
  assign f_act = active && (slot < SLOT_W'(NUM_SEG));
  assign b_act = active && (slot != '0);
  assign f_seg = SW'(slot);
  assign b_seg = SW'(slot - SLOT_W'(1));

  logic [IDX_W-1:0] f_index, b_index;
  logic [LW-1:0]    f_sm, b_sm;
  logic             f_bank, b_bank;
  logic [BAW-1:0]   f_baddr, b_baddr;

  fbs_addr_gen #(.SEG_LEN(SEG_LEN), .NUM_SEG(NUM_SEG), .BACKWARD(1'b0)) fwd_gen_i (
    .seg(f_seg), .cyc(cyc), .index(f_index), .sm_addr(f_sm),
    .bank(f_bank), .bank_addr(f_baddr)
  );
  fbs_addr_gen #(.SEG_LEN(SEG_LEN), .NUM_SEG(NUM_SEG), .BACKWARD(1'b1)) bwd_gen_i (
    .seg(b_seg), .cyc(cyc), .index(b_index), .sm_addr(b_sm),
    .bank(b_bank), .bank_addr(b_baddr)
  );

  logic          s_en, s_zero, v_en;
  logic [SW-1:0] s_idx, v_idx;
  fbs_boundary_ctl #(.SEG_LEN(SEG_LEN), .NUM_SEG(NUM_SEG)) bnd_i (
    .bwd_act(b_act), .first_iter(iter == '0), .seg(b_seg), .cyc(cyc),
    .seed_en(s_en), .seed_zero(s_zero), .seed_idx(s_idx),
    .save_en(v_en), .save_idx(v_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0; done <= 1'b0; last_q <= 1'b0; iter_idx <= '0; cm_buf <= 1'b0;
      fwd_en <= 1'b0; fwd_index <= '0; sm_wr_addr <= '0; fwd_bank <= 1'b0; fwd_bank_addr <= '0;
      bwd_en <= 1'b0; bwd_index <= '0; sm_rd_addr <= '0; bwd_bank <= 1'b0; bwd_bank_addr <= '0;
      seed_en <= 1'b0; seed_zero <= 1'b0; seed_idx <= '0; save_en <= 1'b0; save_idx <= '0;
    end else begin
      if (accept) cm_buf <= ~cm_buf;
      busy          <= active;
      last_q        <= last_step;
      done          <= last_q;
      iter_idx      <= iter;
      fwd_en        <= f_act;
      fwd_index     <= f_index;
      sm_wr_addr    <= f_sm;
      fwd_bank      <= f_bank;
      fwd_bank_addr <= f_baddr;
      bwd_en        <= b_act;
      bwd_index     <= b_index;
      sm_rd_addr    <= b_sm;
      bwd_bank      <= b_bank;
      bwd_bank_addr <= b_baddr;
      seed_en       <= s_en;
      seed_zero     <= s_zero;
      seed_idx      <= s_idx;
      save_en       <= v_en;
      save_idx      <= v_idx;
    end
  end

  assert_sm_share_R6: assert property (@(posedge clk) disable iff (rst)
    (fwd_en && bwd_en) |-> (sm_wr_addr == sm_rd_addr));
  assert_bank_split_R7: assert property (@(posedge clk) disable iff (rst)
    (fwd_en && bwd_en) |-> (fwd_bank != bwd_bank));
  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  assert_busy_fall_R10: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);
  assert_buf_hold_R11: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(cm_buf));
  assert_seed_busy_R8: assert property (@(posedge clk) disable iff (rst)
    (seed_en || save_en) |-> bwd_en);
endmodule

// File: tb/fbs_sched_ctrl_tb.sv
module fbs_sched_ctrl_tb_top;
  localparam int L = 4, NS = 4, IW = 3;
  localparam int LW = 2, SW = 2, IDX_W = 4, BAW = 3;
  localparam int T = (NS + 1) * L;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic [IW-1:0] num_iters = '0;
  logic busy, done, cm_buf, fwd_en, fwd_bank, bwd_en, bwd_bank;
  logic seed_en, seed_zero, save_en;
  logic [IW-1:0] iter_idx;
  logic [IDX_W-1:0] fwd_index, bwd_index;
  logic [LW-1:0] sm_wr_addr, sm_rd_addr;
  logic [BAW-1:0] fwd_bank_addr, bwd_bank_addr;
  logic [SW-1:0] seed_idx, save_idx;

  int n_cmp = 0, n_bad = 0;

  always #2 clk = ~clk;

  fbs_sched_ctrl #(.SEG_LEN(L), .NUM_SEG(NS), .ITER_W(IW)) dut_i (
    .clk(clk), .rst(rst), .start(start), .num_iters(num_iters),
    .busy(busy), .done(done), .iter_idx(iter_idx), .cm_buf(cm_buf),
    .fwd_en(fwd_en), .fwd_index(fwd_index), .sm_wr_addr(sm_wr_addr),
    .fwd_bank(fwd_bank), .fwd_bank_addr(fwd_bank_addr),
    .bwd_en(bwd_en), .bwd_index(bwd_index), .sm_rd_addr(sm_rd_addr),
    .bwd_bank(bwd_bank), .bwd_bank_addr(bwd_bank_addr),
    .seed_en(seed_en), .seed_zero(seed_zero), .seed_idx(seed_idx),
    .save_en(save_en), .save_idx(save_idx)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // Run one job and compare every step; inj_start pulses start mid-run (R2).
  task automatic run_job(input int ni, input bit inj_start, input int exp_buf);
    int iters;
    iters = (ni == 0) ? 1 : ni;
    num_iters = IW'(ni);
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    num_iters = IW'(7);
    for (int it = 0; it < iters; it++) begin
      for (int k = 0; k < T; k++) begin
        int t, c, s, j;
        @(posedge clk);
        @(negedge clk);
        start = (inj_start && it == 0 && k == 5);
        t = k / L; c = k % L;
        chk("R3 busy", busy, 1);
        chk("R10 done low mid-run", done, 0);
        chk("R3 iter_idx", iter_idx, it);
        chk("R11 cm_buf", cm_buf, exp_buf);
        chk("R4 fwd_en", fwd_en, (t < NS) ? 1 : 0);
        if (t < NS) begin
          chk("R4 fwd_index", fwd_index, t * L + c);
          chk("R6 sm_wr_addr", sm_wr_addr, (t % 2 == 0) ? c : L - 1 - c);
          chk("R7 fwd_bank", fwd_bank, t % 2);
          chk("R7 fwd_bank_addr", fwd_bank_addr, (t / 2) * L + c);
        end
        chk("R5 bwd_en", bwd_en, (t >= 1) ? 1 : 0);
        chk("R8 seed_en", seed_en, (t >= 1 && c == 0) ? 1 : 0);
        chk("R9 save_en", save_en, (t >= 2 && c == L - 1) ? 1 : 0);
        if (t >= 1) begin
          s = t - 1; j = L - 1 - c;
          chk("R5 bwd_index", bwd_index, s * L + j);
          chk("R6 sm_rd_addr", sm_rd_addr, (s % 2 == 0) ? j : L - 1 - j);
          chk("R7 bwd_bank", bwd_bank, s % 2);
          chk("R7 bwd_bank_addr", bwd_bank_addr, (s / 2) * L + j);
          if (c == 0) begin
            chk("R8 seed_idx", seed_idx, s);
            chk("R8 seed_zero", seed_zero, (it == 0 || s == NS - 1) ? 1 : 0);
          end
          if (c == L - 1 && s >= 1) chk("R9 save_idx", save_idx, s - 1);
        end
      end
    end
    start = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk("R10 done pulse", done, 1);
    chk("R10 busy fell", busy, 0);
    chk("R10 fwd idle", fwd_en, 0);
    @(posedge clk);
    @(negedge clk);
    chk("R10 done single", done, 0);
    chk("R11 cm_buf hold", cm_buf, exp_buf);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 busy", busy, 0);
    chk("R1 done", done, 0);
    chk("R1 fwd_en", fwd_en, 0);
    chk("R1 bwd_en", bwd_en, 0);
    chk("R1 cm_buf", cm_buf, 0);
    rst = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk("R1 idle after release", busy + seed_en + save_en, 0);
    run_job(3, 1'b1, 1);
    run_job(1, 1'b0, 0);
    run_job(0, 1'b0, 1);
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R2 stays idle", busy, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #100000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule